// File: doc/BRIEF.md
# Segment Descriptor Address Checker

This block turns a segment-relative offset into a flat linear address and checks the access against the segment's descriptor. It takes the fields of a descriptor that is already loaded: base, 20-bit limit, granularity, present bit, privilege level, code/data kind, read/write right and the expand-down flag. With them it takes the 32-bit offset, the kind of access and the current privilege level of the requester. One clock after an input is accepted, it returns the linear address, a fault flag and a fault cause code.

The limit is scaled by the granularity bit. For data segments the expand-down flag turns the limit test around. Privilege and the segment's rights can also block the access. When more than one check fails, a fixed priority picks the cause that is reported. The linear address is still driven when there is a fault, but the requester must not use it in that case.

Top module: `seg_addr_check`

## Requirements
- R1: One cycle after an accepted input, `lin_addr` equals `desc_base + offset`, wrapped modulo 2^32.
- R2: `in_ready` is low while reset is held and high after it. `out_valid` is high in exactly the cycle after a cycle with `in_valid && in_ready`, and low in every other cycle. All outputs are zero after reset.
- R3: An access with `desc_present` = 0 reports cause 1 (absent), whatever the other fields hold.
- R4: When `cpl` is numerically greater than `desc_dpl`, the access reports cause 2 (privilege). When `cpl` is less than or equal to `desc_dpl`, there is no privilege fault.
- R5: With `desc_gran` = 0 the effective limit is the 20-bit limit in bytes. On an expand-up segment, an offset equal to the limit passes and an offset one above it reports cause 4 (limit).
- R6: With `desc_gran` = 1 the effective limit is the limit shifted left 12 bits, with the low 12 bits set to one.
- R7: On an expand-down data segment (`desc_code` = 0, `desc_expdn` = 1), an offset at or below the effective limit reports cause 4. Offsets above the limit, up to 0xFFFFFFFF, pass. On code segments `desc_expdn` is ignored.
- R8: The access codes are 0 = read, 1 = write and 2 = execute. A write reports cause 3 (rights) on a code segment, or on a data segment with `desc_rw` = 0 (read-only).
- R9: A read of a code segment with `desc_rw` = 0 (execute-only) reports cause 3. An execute of a data segment reports cause 3. The reserved access code 3 always reports cause 3.
- R10: Only one cause is reported. The priority is absent (1), then privilege (2), then rights (3), then limit (4). `fault` is high exactly when the cause is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | 1 = limit counts 4096-byte units |
| desc_present | input | 1 | Segment present |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_code | input | 1 | 1 = code segment, 0 = data segment |
| desc_rw | input | 1 | Data: writable; code: readable |
| desc_expdn | input | 1 | Data segment grows downward |
| offset | input | 32 | Offset within the segment |
| access | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| cpl | input | 2 | Current privilege level |
| out_valid | output | 1 | Result valid this cycle |
| lin_addr | output | 32 | Linear address |
| fault | output | 1 | Access faults |
| cause | output | 3 | 0 none, 1 absent, 2 privilege, 3 rights, 4 limit |

## Verification
All results go through a single output register, so a faulty comparator or priority path shows up at the ports in the cycle right after the request: as a wrong `cause` or a wrong `fault` flag. The tests probe the limit compares at the exact boundary offsets (limit, limit+1, and the page-scaled edges) in both growth directions, because an off-by-one error there would otherwise stay hidden. The tests that combine several faults expose a wrong priority order at once. A stuck acceptance flag shows as `out_valid` rising without a request, or failing to rise after one.

// File: rtl/seg_chk_pkg.sv
// Shared encodings for the segment address checker.
// Assumes access kinds and fault causes fit the widths below.
package seg_chk_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ABSENT = 3'd1,
        CAUSE_PRIV   = 3'd2,
        CAUSE_RIGHTS = 3'd3,
        CAUSE_LIMIT  = 3'd4
    } cause_e;
endpackage

// File: rtl/seg_limit_cmp.sv
// Scales the raw limit by granularity and tests the offset against it.
// Assumes LIMIT_W + PAGE_SHIFT <= ADDR_W; grow_down is already qualified
// so that it is set only for data segments.
module seg_limit_cmp #(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [LIMIT_W-1:0] raw_limit,
    input  logic               gran,
    input  logic               grow_down,
    input  logic [ADDR_W-1:0]  off,
    output logic               viol
);
    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((64'd1 << PAGE_SHIFT) - 64'd1);

    logic [ADDR_W-1:0] lim_ext;
    logic [ADDR_W-1:0] eff_lim;
    logic              above;

    // Widen the raw limit and apply page scaling when granularity is set.
    always_comb begin
        lim_ext = ADDR_W'(raw_limit);
        eff_lim = gran ? ((lim_ext << PAGE_SHIFT) | LOW_ONES) : lim_ext;
    end

    // Expand-up passes at or below the limit; expand-down passes strictly above.
    always_comb begin
        above = off > eff_lim;
        viol  = grow_down ? !above : above;
    end
endmodule

// File: rtl/seg_rights_chk.sv
// Decides whether the access kind is allowed by the segment type.
// Assumes rw means writable for data and readable for code.
module seg_rights_chk
    import seg_chk_pkg::*;
(
    input  logic [1:0] acc,
    input  logic       is_code,
    input  logic       rw,
    output logic       bad
);
    // Rights table by access kind; reserved kind is always refused.
    always_comb begin
        case (acc_e'(acc))
            ACC_READ:  bad = is_code && !rw;
            ACC_WRITE: bad = is_code || !rw;
            ACC_EXEC:  bad = !is_code;
            default:   bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/seg_cause_sel.sv
// Reduces the individual check results to a single prioritized cause.
// Assumes each input flag is computed independently of the others.
module seg_cause_sel
    import seg_chk_pkg::*;
(
    input  logic   present,
    input  logic   priv_bad,
    input  logic   rights_bad,
    input  logic   limit_bad,
    output cause_e sel
);
    // Fixed order: absent, privilege, rights, limit.
    always_comb begin
        if (!present)        sel = CAUSE_ABSENT;
        else if (priv_bad)   sel = CAUSE_PRIV;
        else if (rights_bad) sel = CAUSE_RIGHTS;
        else if (limit_bad)  sel = CAUSE_LIMIT;
        else                 sel = CAUSE_NONE;
    end
endmodule

// File: rtl/seg_addr_check.sv
// Segment address checker: forms base+offset and checks presence,
// privilege, type rights and limit in one registered stage.
// Assumes the descriptor fields stay valid for the accepting cycle only.
module seg_addr_check
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LIMIT_W    = 20,
    parameter int PAGE_SHIFT = 12,
    parameter int PL_W       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ADDR_W-1:0]  desc_base,
    input  logic [LIMIT_W-1:0] desc_limit,
    input  logic               desc_gran,
    input  logic               desc_present,
    input  logic [PL_W-1:0]    desc_dpl,
    input  logic               desc_code,
    input  logic               desc_rw,
    input  logic               desc_expdn,
    input  logic [ADDR_W-1:0]  offset,
    input  logic [1:0]         access,
    input  logic [PL_W-1:0]    cpl,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  lin_addr,
    output logic               fault,
    output logic [2:0]         cause
);
    logic              ready_q;
    logic              fire;
    logic              priv_bad;
    logic              rights_bad;
    logic              limit_bad;
    cause_e            cause_d;
    logic [ADDR_W-1:0] sum_d;

    assign in_ready = ready_q;
    assign fire     = in_valid && ready_q;

    // Requester privilege must not be numerically above the descriptor's.
    assign priv_bad = cpl > desc_dpl;

    // Linear address wraps naturally at the address width.
    assign sum_d = desc_base + offset;

    seg_rights_chk u_rights (
        .acc     (access),
        .is_code (desc_code),
        .rw      (desc_rw),
        .bad     (rights_bad)
    );

    seg_limit_cmp #(
        .ADDR_W     (ADDR_W),
        .LIMIT_W    (LIMIT_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_limit (
        .raw_limit (desc_limit),
        .gran      (desc_gran),
        .grow_down (desc_expdn && !desc_code),
        .off       (offset),
        .viol      (limit_bad)
    );

    seg_cause_sel u_sel (
        .present    (desc_present),
        .priv_bad   (priv_bad),
        .rights_bad (rights_bad),
        .limit_bad  (limit_bad),
        .sel        (cause_d)
    );

    // Ready comes up on the first cycle out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Result register: captures address and verdict on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            lin_addr  <= '0;
            fault     <= 1'b0;
            cause     <= 3'd0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                lin_addr <= sum_d;
                fault    <= (cause_d != CAUSE_NONE);
                cause    <= cause_d;
            end
        end
    end
endmodule

// File: rtl/seg_addr_check_sva.sv
// Property checker for seg_addr_check, attached through bind.
// Assumes default parameters of the top module for port widths.
module seg_addr_check_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] desc_base,
    input logic [19:0] desc_limit,
    input logic        desc_gran,
    input logic        desc_present,
    input logic [1:0]  desc_dpl,
    input logic        desc_code,
    input logic        desc_rw,
    input logic        desc_expdn,
    input logic [31:0] offset,
    input logic [1:0]  access,
    input logic [1:0]  cpl,
    input logic        out_valid,
    input logic [31:0] lin_addr,
    input logic        fault,
    input logic [2:0]  cause
);
    AST_LIN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> lin_addr == $past(desc_base + offset)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid && in_ready)); // R2

    AST_ABSENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(!desc_present)) |-> cause == 3'd1); // R3

    AST_PRIV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(desc_present && (cpl > desc_dpl))) |-> cause == 3'd2); // R4

    AST_FAULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> fault == (cause != 3'd0)); // R10

    AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cause <= 3'd4); // R10
endmodule

bind seg_addr_check seg_addr_check_sva u_sva (.*);

// File: tb/seg_addr_check_bench.sv
module seg_addr_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0;
    logic        desc_present = 1'b0;
    logic [1:0]  desc_dpl = '0;
    logic        desc_code = 1'b0;
    logic        desc_rw = 1'b0;
    logic        desc_expdn = 1'b0;
    logic [31:0] offset = '0;
    logic [1:0]  access = '0;
    logic [1:0]  cpl = '0;
    logic        out_valid;
    logic [31:0] lin_addr;
    logic        fault;
    logic [2:0]  cause;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    seg_addr_check u_seg_addr_check (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request, check the registered result, then check idle.
    task automatic xfer(input string tag,
                        input logic [31:0] base, input logic [19:0] lim, input logic gran,
                        input logic pres, input logic [1:0] dpl, input logic code,
                        input logic rw, input logic ed, input logic [1:0] acc,
                        input logic [31:0] off, input logic [1:0] pl,
                        input logic [31:0] exp_lin, input logic [2:0] exp_cause);
        @(negedge clk);
        desc_base = base; desc_limit = lim; desc_gran = gran; desc_present = pres;
        desc_dpl = dpl; desc_code = code; desc_rw = rw; desc_expdn = ed;
        access = acc; offset = off; cpl = pl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " valid"}, 32'(out_valid), 32'd1);
        chk({tag, " cause"}, 32'(cause), 32'(exp_cause));
        chk({tag, " fault"}, 32'(fault), 32'(exp_cause != 3'd0));
        if (exp_cause == 3'd0) chk({tag, " lin"}, lin_addr, exp_lin);
        @(negedge clk);
        chk({tag, " valid drop"}, 32'(out_valid), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R2 ready in reset", 32'(in_ready), 32'd0);
        chk("R2 out_valid reset", 32'(out_valid), 32'd0);
        chk("R2 lin reset", lin_addr, 32'd0);
        chk("R2 cause reset", 32'(cause), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 ready after reset", 32'(in_ready), 32'd1);
        @(negedge clk);
        chk("R2 no valid without request", 32'(out_valid), 32'd0);
    endtask

    task automatic t_linear();
        xfer("R1 plain", 32'h1000_0000, 20'h000FF, 0, 1, 0, 0, 1, 0, 2'd0, 32'h34, 0, 32'h1000_0034, 3'd0);
        xfer("R1 wrap", 32'hFFFF_F000, 20'hFFFFF, 1, 1, 0, 0, 1, 0, 2'd0, 32'h2000, 0, 32'h0000_1000, 3'd0);
    endtask

    task automatic t_absent();
        xfer("R3 absent", 32'h0, 20'h0, 0, 0, 0, 0, 0, 0, 2'd1, 32'h10, 3, 32'h10, 3'd1);
    endtask

    task automatic t_priv();
        xfer("R4 cpl3 dpl0", 32'h0, 20'hFFFFF, 0, 1, 0, 0, 1, 0, 2'd0, 32'h0, 3, 32'h0, 3'd2);
        xfer("R4 cpl0 dpl3", 32'h40, 20'hFFFFF, 0, 1, 3, 0, 1, 0, 2'd0, 32'h4, 0, 32'h44, 3'd0);
        xfer("R4 equal", 32'h40, 20'hFFFFF, 0, 1, 2, 0, 1, 0, 2'd0, 32'h8, 2, 32'h48, 3'd0);
    endtask

    task automatic t_byte_limit();
        xfer("R5 at limit", 32'h0, 20'h00100, 0, 1, 0, 0, 1, 0, 2'd0, 32'h100, 0, 32'h100, 3'd0);
        xfer("R5 over limit", 32'h0, 20'h00100, 0, 1, 0, 0, 1, 0, 2'd0, 32'h101, 0, 32'h101, 3'd4);
    endtask

    task automatic t_page_limit();
        xfer("R6 page edge", 32'h0, 20'h00002, 1, 1, 0, 0, 1, 0, 2'd0, 32'h2FFF, 0, 32'h2FFF, 3'd0);
        xfer("R6 page over", 32'h0, 20'h00002, 1, 1, 0, 0, 1, 0, 2'd0, 32'h3000, 0, 32'h3000, 3'd4);
    endtask

    task automatic t_expdown();
        xfer("R7 at limit", 32'h0, 20'h00FFF, 0, 1, 0, 0, 1, 1, 2'd1, 32'h0FFF, 0, 32'h0FFF, 3'd4);
        xfer("R7 above", 32'h0, 20'h00FFF, 0, 1, 0, 0, 1, 1, 2'd1, 32'h1000, 0, 32'h1000, 3'd0);
        xfer("R7 top", 32'h0, 20'h00FFF, 0, 1, 0, 0, 1, 1, 2'd0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 3'd0);
        xfer("R7 page low", 32'h0, 20'h00001, 1, 1, 0, 0, 1, 1, 2'd0, 32'h1FFF, 0, 32'h1FFF, 3'd4);
        xfer("R7 page ok", 32'h0, 20'h00001, 1, 1, 0, 0, 1, 1, 2'd0, 32'h2000, 0, 32'h2000, 3'd0);
        xfer("R7 code ignores", 32'h0, 20'h00FFF, 0, 1, 0, 1, 1, 1, 2'd2, 32'h10, 0, 32'h10, 3'd0);
    endtask

    task automatic t_write_rights();
        xfer("R8 ro write", 32'h0, 20'hFFFFF, 0, 1, 0, 0, 0, 0, 2'd1, 32'h10, 0, 32'h10, 3'd3);
        xfer("R8 rw write", 32'h0, 20'hFFFFF, 0, 1, 0, 0, 1, 0, 2'd1, 32'h10, 0, 32'h10, 3'd0);
        xfer("R8 code write", 32'h0, 20'hFFFFF, 0, 1, 0, 1, 1, 0, 2'd1, 32'h10, 0, 32'h10, 3'd3);
    endtask

    task automatic t_other_rights();
        xfer("R9 exec-only read", 32'h0, 20'hFFFFF, 0, 1, 0, 1, 0, 0, 2'd0, 32'h10, 0, 32'h10, 3'd3);
        xfer("R9 readable code", 32'h0, 20'hFFFFF, 0, 1, 0, 1, 1, 0, 2'd0, 32'h10, 0, 32'h10, 3'd0);
        xfer("R9 data exec", 32'h0, 20'hFFFFF, 0, 1, 0, 0, 1, 0, 2'd2, 32'h10, 0, 32'h10, 3'd3);
        xfer("R9 reserved", 32'h0, 20'hFFFFF, 0, 1, 0, 1, 1, 0, 2'd3, 32'h10, 0, 32'h10, 3'd3);
    endtask

    task automatic t_priority();
        xfer("R10 absent over all", 32'h0, 20'h1, 0, 0, 0, 0, 0, 0, 2'd1, 32'h100, 3, 32'h100, 3'd1);
        xfer("R10 priv over rights", 32'h0, 20'h1, 0, 1, 0, 0, 0, 0, 2'd1, 32'h100, 3, 32'h100, 3'd2);
        xfer("R10 rights over limit", 32'h0, 20'h1, 0, 1, 0, 0, 0, 0, 2'd1, 32'h100, 0, 32'h100, 3'd3);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_linear();
                t_absent();
                t_priv();
                t_byte_limit();
                t_page_limit();
                t_expdown();
                t_write_rights();
                t_other_rights();
                t_priority();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule